// File: doc/BRIEF.md
# Block-Transfer Micro-op Sequencer

This block takes one 32-bit multi-register transfer instruction and turns it into a serial stream of simple micro-ops. It emits one micro-op per clock while the consumer is ready. The instruction holds three fields. Bits 24:20 are a five-bit mode: bit 24 selects before or after, bit 23 selects up or down, bit 22 is the user-bank bit, bit 21 is writeback and bit 20 is load. Bits 19:16 name the base register. Bits 15:0 form the register list, with bit i selecting register i.

Every legal instruction produces the same stream. The first micro-op is a copy of the base register. It is followed by one single-register transfer for each selected register, and each transfer carries its signed byte offset. A base-update micro-op comes last when writeback is requested, and the final micro-op of every stream is flagged. An instruction with an unsupported mode produces a single illegal-instruction micro-op instead. Both sides use valid/ready handshakes. The sequencer accepts a new instruction only when it is idle.

Top module: `ldm_uop_seq`

## Requirements
- R1: After reset, and after a reset applied in the middle of a sequence, `in_ready` is 1 and `out_valid` is 0.
- R2: A legal instruction yields exactly n+1+W micro-ops. Here n is the number of set bits in bits 15:0 and W is bit 21. No micro-op follows the flagged one.
- R3: The first micro-op of a legal instruction has kind 0 (copy). Its word is the instruction with bits 15:0 cleared and bits 31:16 kept.
- R4: Transfer micro-ops have kind 1. They visit the set list bits from the lowest index to the highest, one register each. `out_reg` is the index, `out_load` is bit 20 and the word is the whole instruction. On all other micro-ops `out_reg` and `out_offset` are 0 and `out_load` still shows bit 20.
- R5: The offset of the first transfer depends on the mode. Modes 0x01/0x03 start at 4n-4, modes 0x08/0x09/0x0B start at 0, modes 0x11/0x12 start at 4n, and modes 0x18/0x19 start at 4.
- R6: Each following transfer offset is the previous offset +4 when bit 23 is 1 and -4 when it is 0, in 32-bit two's complement.
- R7: Any mode other than 0x01, 0x03, 0x08, 0x09, 0x0B, 0x11, 0x12, 0x18 or 0x19 yields one micro-op of kind 4 (illegal). Its word is the instruction and its last flag is set.
- R8: When bit 21 is set, the final micro-op is the base update. Its kind is 2 (add) when bit 23 is 1 and 3 (subtract) otherwise. Its word is {bits 31:28, 8'h24, base, base, 4'h0, 8-bit 4n}.
- R9: `out_last` is 1 on the final micro-op of each stream and 0 on every other micro-op.
- R10: `in_ready` is 0 from the cycle after an accept until the flagged micro-op has been taken. It is 1 in the cycle after that.
- R11: While `out_valid` is 1 and `out_ready` is 0, every output field holds its value.
- R12: An empty list with a legal mode yields only the copy micro-op and, if bit 21 is set, the update micro-op with immediate 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The sequencer is idle and takes the instruction |
| in_instr | input | 32 | Block-transfer instruction word |
| out_valid | output | 1 | A micro-op is presented |
| out_ready | input | 1 | The consumer takes the micro-op |
| out_kind | output | 3 | 0 copy, 1 transfer, 2 add update, 3 subtract update, 4 illegal |
| out_word | output | 32 | Encoded micro-op word |
| out_load | output | 1 | Load (1) or store (0) |
| out_reg | output | 4 | Register index of a transfer |
| out_offset | output | 32 | Signed byte offset of a transfer |
| out_last | output | 1 | Final micro-op of the stream |

## Verification
Two events can fall in the same clock edge: the consumer takes the flagged last micro-op, and a new instruction is waiting at the input. The bench holds the next instruction valid for the whole stream. It then checks that `in_ready` stays low up to and including the edge that takes the last micro-op, rises in the cycle after, and that the new stream opens with its copy micro-op one cycle later. Consumer stalls are inserted at varying beats, including on the flagged micro-op, so that a held last micro-op is also seen against a waiting instruction.

// File: rtl/ldm_seq_pkg.sv
package ldm_seq_pkg;

   // micro-op kinds presented on out_kind
   typedef enum logic [2:0] {
      UOP_COPY = 3'd0,
      UOP_XFER = 3'd1,
      UOP_ADD  = 3'd2,
      UOP_SUB  = 3'd3,
      UOP_ILL  = 3'd4
   } uop_kind_e;

   // internal stream phase
   typedef enum logic [1:0] {
      PH_COPY,
      PH_XFER,
      PH_UPD,
      PH_ERR
   } seq_phase_e;

   // instruction field positions
   localparam int COND_HI = 31;
   localparam int COND_LO = 28;
   localparam int MODE_HI = 24;
   localparam int MODE_LO = 20;
   localparam int UP_BIT  = 23;
   localparam int WB_BIT  = 21;
   localparam int LD_BIT  = 20;
   localparam int BASE_HI = 19;
   localparam int BASE_LO = 16;
   localparam int LIST_HI = 15;

   // opcode byte placed in bits 27:20 of the update word
   localparam logic [7:0] UPD_OPC = 8'h24;

endpackage

// File: rtl/ldm_popcnt.sv
module ldm_popcnt #(
   parameter int WIDTH = 16,
   parameter int CNT_W = $clog2(WIDTH + 1)
) (
   input  logic [WIDTH-1:0] bits_i,
   output logic [CNT_W-1:0] count_o
);

   always_comb begin
      count_o = '0;
      for (int i = 0; i < WIDTH; i++) begin
         count_o = count_o + CNT_W'(bits_i[i]);
      end
   end

endmodule

// File: rtl/ldm_low_pick.sv
module ldm_low_pick #(
   parameter int WIDTH = 16,
   parameter int IDX_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] mask_i,
   output logic [WIDTH-1:0] onehot_o,
   output logic [IDX_W-1:0] idx_o
);

   logic [WIDTH-1:0] below;

   assign below[0] = 1'b0;

   genvar gi;
   generate
      for (gi = 1; gi < WIDTH; gi++) begin : g_prefix
         assign below[gi] = below[gi-1] | mask_i[gi-1];
      end
   endgenerate

   assign onehot_o = mask_i & ~below;

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < WIDTH; i++) begin
         if (onehot_o[i]) idx_o = idx_o | IDX_W'(i);
      end
   end

endmodule

// File: rtl/ldm_ofs_plan.sv
module ldm_ofs_plan #(
   parameter int CNT_W      = 5,
   parameter int OFS_W      = 32,
   parameter int STEP_BYTES = 4
) (
   input  logic [4:0]       mode_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic [OFS_W-1:0] start_o,
   output logic             legal_o
);

   localparam logic [OFS_W-1:0] STEP_V = OFS_W'(STEP_BYTES);
   localparam bit STEP_POW2 = (STEP_BYTES & (STEP_BYTES - 1)) == 0;
   localparam int STEP_SH   = $clog2(STEP_BYTES);

   logic [OFS_W-1:0] span;

   generate
      if (STEP_POW2) begin : g_shift
         assign span = OFS_W'(cnt_i) << STEP_SH;
      end else begin : g_mult
         assign span = OFS_W'(cnt_i) * STEP_V;
      end
   endgenerate

   always_comb begin
      legal_o = 1'b1;
      start_o = '0;
      unique case (mode_i)
         5'h01, 5'h03:        start_o = span - STEP_V;
         5'h08, 5'h09, 5'h0B: start_o = '0;
         5'h11, 5'h12:        start_o = span;
         5'h18, 5'h19:        start_o = STEP_V;
         default: begin
            legal_o = 1'b0;
            start_o = '0;
         end
      endcase
   end

endmodule

// File: rtl/ldm_uop_seq.sv
module ldm_uop_seq
   import ldm_seq_pkg::*;
#(
   parameter int REG_COUNT  = 16,
   parameter int WORD_W     = 32,
   parameter int OFS_W      = 32,
   parameter int STEP_BYTES = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   output logic                         in_ready,
   input  logic [WORD_W-1:0]            in_instr,
   output logic                         out_valid,
   input  logic                         out_ready,
   output logic [2:0]                   out_kind,
   output logic [WORD_W-1:0]            out_word,
   output logic                         out_load,
   output logic [$clog2(REG_COUNT)-1:0] out_reg,
   output logic [OFS_W-1:0]             out_offset,
   output logic                         out_last
);

   localparam int IDX_W = $clog2(REG_COUNT);
   localparam int CNT_W = $clog2(REG_COUNT + 1);
   localparam int IMM_W = 8;
   localparam logic [OFS_W-1:0] STEP_V = OFS_W'(STEP_BYTES);

   // elaboration-time parameter checks
   generate
      if (REG_COUNT != 16) begin : g_bad_regs
         $error("REG_COUNT must match the 16-bit list field");
      end
      if (WORD_W != 32) begin : g_bad_word
         $error("WORD_W must be 32");
      end
      if (OFS_W < 8) begin : g_bad_ofs
         $error("OFS_W too narrow");
      end
      if (STEP_BYTES < 1 || REG_COUNT * STEP_BYTES > 255) begin : g_bad_step
         $error("STEP_BYTES does not fit the update immediate");
      end
   endgenerate

   // state
   logic                 busy_q;
   seq_phase_e           phase_q;
   logic [WORD_W-1:0]    instr_q;
   logic [REG_COUNT-1:0] pend_q;
   logic [CNT_W-1:0]     cnt_q;
   logic [OFS_W-1:0]     ofs_q;

   // decode of the incoming word
   logic [CNT_W-1:0] in_cnt;
   logic [OFS_W-1:0] in_start;
   logic             in_legal;

   ldm_popcnt #(
      .WIDTH (REG_COUNT),
      .CNT_W (CNT_W)
   ) u_popcnt (
      .bits_i  (in_instr[LIST_HI:0]),
      .count_o (in_cnt)
   );

   ldm_ofs_plan #(
      .CNT_W      (CNT_W),
      .OFS_W      (OFS_W),
      .STEP_BYTES (STEP_BYTES)
   ) u_plan (
      .mode_i  (in_instr[MODE_HI:MODE_LO]),
      .cnt_i   (in_cnt),
      .start_o (in_start),
      .legal_o (in_legal)
   );

   // next register to transfer
   logic [REG_COUNT-1:0] pick_onehot;
   logic [IDX_W-1:0]     pick_idx;
   logic [REG_COUNT-1:0] pend_rest;

   ldm_low_pick #(
      .WIDTH (REG_COUNT),
      .IDX_W (IDX_W)
   ) u_pick (
      .mask_i   (pend_q),
      .onehot_o (pick_onehot),
      .idx_o    (pick_idx)
   );

   assign pend_rest = pend_q & ~pick_onehot;

   // latched instruction fields
   logic            up_q;
   logic            wb_q;
   logic [3:0]      base_q;
   logic [IMM_W-1:0] upd_imm;
   logic [WORD_W-1:0] upd_word;
   logic [OFS_W-1:0] step;

   assign up_q     = instr_q[UP_BIT];
   assign wb_q     = instr_q[WB_BIT];
   assign base_q   = instr_q[BASE_HI:BASE_LO];
   assign upd_imm  = IMM_W'(cnt_q) * IMM_W'(STEP_BYTES);
   assign upd_word = {instr_q[COND_HI:COND_LO], UPD_OPC, base_q, base_q, 4'h0, upd_imm};
   assign step     = up_q ? STEP_V : (~STEP_V + 1'b1);

   wire take = busy_q & out_ready;

   // sequencing
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         phase_q <= PH_COPY;
         instr_q <= '0;
         pend_q  <= '0;
         cnt_q   <= '0;
         ofs_q   <= '0;
      end else if (!busy_q) begin
         if (in_valid) begin
            busy_q  <= 1'b1;
            instr_q <= in_instr;
            pend_q  <= in_instr[LIST_HI:0];
            cnt_q   <= in_cnt;
            ofs_q   <= in_start;
            phase_q <= in_legal ? PH_COPY : PH_ERR;
         end
      end else if (take) begin
         unique case (phase_q)
            PH_COPY: begin
               if (|pend_q)   phase_q <= PH_XFER;
               else if (wb_q) phase_q <= PH_UPD;
               else           busy_q  <= 1'b0;
            end
            PH_XFER: begin
               pend_q <= pend_rest;
               ofs_q  <= ofs_q + step;
               if (pend_rest == '0) begin
                  if (wb_q) phase_q <= PH_UPD;
                  else      busy_q  <= 1'b0;
               end
            end
            PH_UPD, PH_ERR: busy_q <= 1'b0;
            default:        busy_q <= 1'b0;
         endcase
      end
   end

   // output formation
   uop_kind_e kind;

   always_comb begin
      kind       = UOP_ILL;
      out_word   = instr_q;
      out_reg    = '0;
      out_offset = '0;
      out_last   = 1'b0;
      unique case (phase_q)
         PH_COPY: begin
            kind     = UOP_COPY;
            out_word = {instr_q[WORD_W-1:LIST_HI+1], {(LIST_HI+1){1'b0}}};
            out_last = ~(|pend_q) & ~wb_q;
         end
         PH_XFER: begin
            kind       = UOP_XFER;
            out_reg    = pick_idx;
            out_offset = ofs_q;
            out_last   = (pend_rest == '0) & ~wb_q;
         end
         PH_UPD: begin
            kind     = up_q ? UOP_ADD : UOP_SUB;
            out_word = upd_word;
            out_last = 1'b1;
         end
         default: begin
            kind     = UOP_ILL;
            out_last = 1'b1;
         end
      endcase
   end

   assign out_kind  = kind;
   assign out_load  = instr_q[LD_BIT];
   assign out_valid = busy_q;
   assign in_ready  = ~busy_q;

endmodule

// File: rtl/ldm_uop_seq_chk.sv
module ldm_uop_seq_chk
   import ldm_seq_pkg::*;
#(
   parameter int REG_COUNT  = 16,
   parameter int WORD_W     = 32,
   parameter int OFS_W      = 32,
   parameter int STEP_BYTES = 4
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         in_valid,
   input logic                         in_ready,
   input logic [WORD_W-1:0]            in_instr,
   input logic                         out_valid,
   input logic                         out_ready,
   input logic [2:0]                   out_kind,
   input logic [WORD_W-1:0]            out_word,
   input logic                         out_load,
   input logic [$clog2(REG_COUNT)-1:0] out_reg,
   input logic [OFS_W-1:0]             out_offset,
   input logic                         out_last
);

   localparam logic [OFS_W-1:0] STEP_V = OFS_W'(STEP_BYTES);

   wire fire      = out_valid & out_ready;
   wire is_xfer   = out_valid & (out_kind == 3'(UOP_XFER));
   wire fire_xfer = fire & (out_kind == 3'(UOP_XFER));

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_word)
         && $stable(out_reg) && $stable(out_offset) && $stable(out_last)); // R11

   AST_COPY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid &&
         ((out_kind == 3'(UOP_COPY) && out_word[WORD_W-1:16] == $past(in_instr[WORD_W-1:16]))
          || out_kind == 3'(UOP_ILL))); // R3

   AST_REG_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      is_xfer && $past(fire_xfer) |-> out_reg > $past(out_reg)); // R4

   AST_OFS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      is_xfer && $past(fire_xfer) |->
         out_offset == (out_word[UP_BIT] ? $past(out_offset) + STEP_V
                                         : $past(out_offset) - STEP_V)); // R6

   AST_XFER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      is_xfer |-> out_load == out_word[LD_BIT]); // R4

   AST_ILL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_kind == 3'(UOP_ILL) |-> out_last); // R7

   AST_UPD_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && (out_kind == 3'(UOP_ADD) || out_kind == 3'(UOP_SUB))
         |-> out_last && out_word[27:20] == UPD_OPC); // R8

   AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      fire && out_last |=> in_ready && !out_valid); // R10

   AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !(out_ready && out_last) |=> !in_ready); // R10

endmodule

bind ldm_uop_seq ldm_uop_seq_chk #(
   .REG_COUNT  (REG_COUNT),
   .WORD_W     (WORD_W),
   .OFS_W      (OFS_W),
   .STEP_BYTES (STEP_BYTES)
) i_chk (.*);

// File: tb/test_ldm_uop_seq.sv
`timescale 1ns/1ps
module test_ldm_uop_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_instr = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [2:0]  out_kind;
   logic [31:0] out_word;
   logic        out_load;
   logic [3:0]  out_reg;
   logic [31:0] out_offset;
   logic        out_last;

   always #4 clk = ~clk;

   ldm_uop_seq i_ldm_uop_seq (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_instr(in_instr), .out_valid(out_valid), .out_ready(out_ready),
      .out_kind(out_kind), .out_word(out_word), .out_load(out_load),
      .out_reg(out_reg), .out_offset(out_offset), .out_last(out_last)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // expected stream
   logic [2:0]  e_kind [20];
   logic [31:0] e_word [20];
   logic [3:0]  e_reg  [20];
   logic [31:0] e_ofs  [20];
   logic        e_load [20];
   logic        e_last [20];
   int          e_cnt;

   task automatic chk(input bit ok, input string tag, input string act, input string exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%s expected=%s", tag, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [2:0] k, input bit stalled);
      if (stalled) return "R11";
      case (k)
         3'd0: return "R3";
         3'd1: return "R4/R5/R6";
         3'd2, 3'd3: return "R8";
         default: return "R7";
      endcase
   endfunction

   task automatic push(input logic [2:0] k, input logic [31:0] w, input logic [3:0] r,
                       input logic [31:0] o, input logic ld);
      e_kind[e_cnt] = k; e_word[e_cnt] = w; e_reg[e_cnt] = r;
      e_ofs[e_cnt] = o; e_load[e_cnt] = ld; e_last[e_cnt] = 1'b0;
      e_cnt++;
   endtask

   task automatic build_exp(input logic [31:0] ins);
      logic [4:0]  mode;
      logic [31:0] ofs;
      int          n;
      bit          up;
      mode = ins[24:20];
      up   = ins[23];
      n    = 0;
      e_cnt = 0;
      for (int i = 0; i < 16; i++) if (ins[i]) n++;
      if (!(mode inside {5'h01, 5'h03, 5'h08, 5'h09, 5'h0B, 5'h11, 5'h12, 5'h18, 5'h19})) begin
         push(3'd4, ins, 4'd0, 32'd0, ins[20]);
      end else begin
         push(3'd0, {ins[31:16], 16'h0000}, 4'd0, 32'd0, ins[20]);
         case (mode)
            5'h01, 5'h03: ofs = 32'(4 * n) - 32'd4;
            5'h11, 5'h12: ofs = 32'(4 * n);
            5'h18, 5'h19: ofs = 32'd4;
            default:      ofs = 32'd0;
         endcase
         for (int r = 0; r < 16; r++) begin
            if (ins[r]) begin
               push(3'd1, ins, 4'(r), ofs, ins[20]);
               ofs = up ? ofs + 32'd4 : ofs - 32'd4;
            end
         end
         if (ins[21])
            push(up ? 3'd2 : 3'd3,
                 {ins[31:28], 8'h24, ins[19:16], ins[19:16], 4'h0, 8'(4 * n)},
                 4'd0, 32'd0, ins[20]);
      end
      e_last[e_cnt-1] = 1'b1;
   endtask

   // called at a negedge with the copy (or first) micro-op about to be shown
   task automatic drain(input logic [31:0] ins, input int stall_mod);
      int  k;
      int  beat;
      bit  stall;
      build_exp(ins);
      k = 0;
      beat = 0;
      while (k < e_cnt && !done) begin
         stall = (stall_mod != 0) && (beat % stall_mod == 1);
         out_ready = !stall;
         chk(out_valid && out_kind == e_kind[k] && out_word == e_word[k] &&
             out_reg == e_reg[k] && out_offset == e_ofs[k] &&
             out_load == e_load[k] && out_last == e_last[k],
             e_last[k] ? "R9" : tag_of(e_kind[k], stall),
             $sformatf("v%0d k%0d w%h r%0d o%h l%0d last%0d", out_valid, out_kind,
                       out_word, out_reg, out_offset, out_load, out_last),
             $sformatf("v1 k%0d w%h r%0d o%h l%0d last%0d", e_kind[k], e_word[k],
                       e_reg[k], e_ofs[k], e_load[k], e_last[k]));
         chk(!in_ready, "R10", $sformatf("%0d", in_ready), "0");
         @(negedge clk);
         if (!stall) k++;
         beat++;
      end
      out_ready = 1'b0;
      chk(!out_valid && in_ready, "R2",
          $sformatf("valid%0d ready%0d", out_valid, in_ready), "valid0 ready1");
   endtask

   task automatic run_vec(input logic [31:0] ins, input int stall_mod);
      @(negedge clk);
      chk(in_ready, "R10", $sformatf("%0d", in_ready), "1");
      in_instr = ins;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      drain(ins, stall_mod);
   endtask

   localparam int NV = 13;
   localparam logic [31:0] VEC [NV] = '{
      32'hE8B100F0,  // up-after, writeback, load
      32'hE8128001,  // down-after, load, ends at 0
      32'h58330222,  // down-after, writeback, other condition
      32'hE884FFFF,  // up-after store, full list
      32'hE8950008,  // up-after load, single register
      32'hE9161234,  // down-before load
      32'hE92D4FF0,  // down-before store, writeback
      32'hE9870101,  // up-before store
      32'hE998C000,  // up-before load, top registers
      32'hE9B90F00,  // illegal mode 0x1B
      32'hE80A0003,  // illegal mode 0x00
      32'hE8B90000,  // empty list, writeback (R12)
      32'hE89A0000   // empty list, no writeback (R12)
   };

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(in_ready && !out_valid, "R1",
          $sformatf("ready%0d valid%0d", in_ready, out_valid), "ready1 valid0");
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready && !out_valid, "R1",
          $sformatf("ready%0d valid%0d", in_ready, out_valid), "ready1 valid0");

      // table walk: R2..R9, R11, R12
      for (int v = 0; v < NV; v++) begin
         run_vec(VEC[v], (v % 2 == 1) ? 3 : 0);
      end

      // stall on the flagged micro-op itself (R11)
      run_vec(32'hE8950008, 2);

      // next instruction waiting while the last one is taken (R10)
      @(negedge clk);
      in_instr  = 32'hE8950008;
      in_valid  = 1'b1;
      out_ready = 1'b1;
      @(negedge clk);
      in_instr = 32'hE9870101;
      chk(out_valid && out_kind == 3'd0 && !in_ready, "R10",
          $sformatf("k%0d ready%0d", out_kind, in_ready), "k0 ready0");
      @(negedge clk);
      chk(out_valid && out_kind == 3'd1 && out_last && out_reg == 4'd3 && !in_ready, "R10",
          $sformatf("k%0d last%0d r%0d ready%0d", out_kind, out_last, out_reg, in_ready),
          "k1 last1 r3 ready0");
      @(negedge clk);
      chk(!out_valid && in_ready, "R10",
          $sformatf("valid%0d ready%0d", out_valid, in_ready), "valid0 ready1");
      out_ready = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;
      drain(32'hE9870101, 0);

      // reset in the middle of a stream (R1)
      @(negedge clk);
      in_instr  = 32'hE884FFFF;
      in_valid  = 1'b1;
      @(negedge clk);
      in_valid  = 1'b0;
      out_ready = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      out_ready = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready && !out_valid, "R1",
          $sformatf("ready%0d valid%0d", in_ready, out_valid), "ready1 valid0");
      run_vec(32'hE92D4FF0, 0);

      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule